// File: doc/BRIEF.md
# Array Self-Test Controller

This block checks an on-chip register file or small memory array by itself. It sits between the array and the logic that normally uses it. While a test runs, it takes the array's address, write-data and write-enable lines away from the normal port. It writes a seeded pseudo-random data pattern into every location. It then reads every location back and folds each returned word into a multiple-input signature register. At the end it compares the signature with an expected value, which is a parameter.

The test runs by itself when reset is released, so the part checks its own array at each power-up. A start pulse repeats the test later. Accesses are issued on every cycle with no idle gaps, so the array is exercised back to back. The result appears on a done flag and a pass flag, which hold their values until the next start or reset. The array is assumed to be read asynchronously: its read data reflects the address in the same cycle.

Top module: `array_bist`

## Requirements
- R1: While busy is high, the array lines come from the test engine. A normal-port write (sys_we) has no effect on the array, and sys_rdata reads 0.
- R2: During reset, done and pass are 0. With AUTO_START=1, busy is high from the first cycle after reset and the test runs with no start pulse.
- R3: The write pass lasts DEPTH consecutive cycles. It writes addresses 0 to DEPTH-1 in ascending order. The data starts at SEED and each next word is {d[DW-2:0], ^(d & TAP)}, where TAP is 8'hB8 for DW=8.
- R4: The read pass follows at once and lasts DEPTH consecutive cycles, reading addresses 0 to DEPTH-1 in ascending order. busy stays high for exactly 2*DEPTH cycles with no gap.
- R5: The signature starts at 0. On each read it becomes {s[DW-2:0], ^(s & TAP)} ^ rdata.
- R6: On the edge that ends the last read, busy falls and done rises. pass is set to 1 if and only if the final signature equals EXP_SIG.
- R7: done and pass keep their values until start is accepted or reset is asserted.
- R8: start is accepted when busy is low. busy is then high on the next cycle, done falls, and a full new test runs from SEED. start has no effect while busy is high.
- R9: If one array bit is stuck at the opposite of the value the pattern writes there, the test ends with pass at 0.
- R10: When busy is low, sys_addr, sys_wdata and sys_we drive the array directly, and sys_rdata returns the array's read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts a new test when not busy |
| sys_addr | input | AW | Normal-port address |
| sys_wdata | input | DW | Normal-port write data |
| sys_we | input | 1 | Normal-port write enable |
| sys_rdata | output | DW | Normal-port read data, 0 while busy |
| arr_addr | output | AW | Address to the array |
| arr_wdata | output | DW | Write data to the array |
| arr_we | output | 1 | Write enable to the array |
| arr_rdata | input | DW | Asynchronous read data from the array |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, result valid |
| pass | output | 1 | Final signature matched EXP_SIG |

## Verification
The test is run four ways:
- A fault-free array gives pass at 1. This shows that the write pattern, the read order and the signature arithmetic all agree with an independent model.
- The same array with one bit stuck at the opposite of its written value gives pass at 0. This shows that the compressed signature catches a single-bit error.
- A start pulse given partway through a run must leave the busy window at exactly 2*DEPTH cycles. This separates an ignored request from a restart.
- A normal-port write held during the whole test must leave the array contents unchanged. This separates correct port multiplexing from leakage of normal-port traffic into the array.

// File: rtl/array_bist_pkg.sv
// Package: shared state encoding and feedback taps for the array self-test.
// Assumes the data width is one of 4, 8 or 16 bits; any other width uses the 8-bit taps.
package array_bist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_DONE  = 2'd3
    } bist_state_e;

    // Returns the feedback mask of a maximal-length shift register of width w.
    function automatic logic [31:0] tap_mask(input int w);
        case (w)
            4:       return 32'h0000_000C;
            16:      return 32'h0000_B400;
            default: return 32'h0000_00B8;
        endcase
    endfunction

endpackage

// File: rtl/bist_lfsr.sv
// Pattern source: a Fibonacci shift register that shifts left with its feedback entering bit 0.
// Assumes the SEED parameter is nonzero. The load input has priority over the advance input.
module bist_lfsr #(
    parameter int           DW   = 8,
    parameter logic [DW-1:0] SEED = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    output logic [DW-1:0] q
);
    localparam logic [DW-1:0] TAP = DW'(array_bist_pkg::tap_mask(DW));

    // Load the seed or step the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            q <= SEED;
        else if (advance)
            q <= {q[DW-2:0], ^(q & TAP)};
    end
endmodule

// File: rtl/bist_misr.sv
// Signature register: shifts like the pattern source and XORs one data word into itself per enabled cycle.
// Provides the next value as well, so that the caller can compare in the same cycle as the last update.
module bist_misr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] sig,
    output logic [DW-1:0] sig_nxt
);
    localparam logic [DW-1:0] TAP = DW'(array_bist_pkg::tap_mask(DW));

    // Next signature value for the current input word.
    always_comb sig_nxt = {sig[DW-2:0], ^(sig & TAP)} ^ din;

    // Clear to zero or absorb one word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            sig <= '0;
        else if (en)
            sig <= sig_nxt;
    end
endmodule

// File: rtl/bist_port_mux.sv
// Port selector: gives the array either to the normal port or to the test engine.
// While test_en is high, the normal port's read data is forced to zero.
module bist_port_mux #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          test_en,
    input  logic [AW-1:0] sys_addr,
    input  logic [DW-1:0] sys_wdata,
    input  logic          sys_we,
    output logic [DW-1:0] sys_rdata,
    input  logic [AW-1:0] tst_addr,
    input  logic [DW-1:0] tst_wdata,
    input  logic          tst_we,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic          arr_we,
    input  logic [DW-1:0] arr_rdata
);
    // Select the source of the array lines and gate the read-back.
    always_comb begin
        arr_addr  = test_en ? tst_addr  : sys_addr;
        arr_wdata = test_en ? tst_wdata : sys_wdata;
        arr_we    = test_en ? tst_we    : sys_we;
        sys_rdata = test_en ? '0        : arr_rdata;
    end
endmodule

// File: rtl/array_bist.sv
// Array self-test controller. It runs a write pass and then a read pass over DEPTH words with no idle
// cycles, compresses the read data into a signature and compares the signature with EXP_SIG.
// Assumes the array reads asynchronously and that EXP_SIG matches SEED and DEPTH for a good array.
module array_bist #(
    parameter int            DEPTH      = 16,
    parameter int            DW         = 8,
    parameter logic [DW-1:0] SEED       = 8'hA5,
    parameter logic [DW-1:0] EXP_SIG    = 8'h00,
    parameter bit            AUTO_START = 1'b1,
    localparam int           AW         = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] sys_addr,
    input  logic [DW-1:0] sys_wdata,
    input  logic          sys_we,
    output logic [DW-1:0] sys_rdata,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic          arr_we,
    input  logic [DW-1:0] arr_rdata,
    output logic          busy,
    output logic          done,
    output logic          pass
);
    import array_bist_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    bist_state_e   state_q;
    logic [AW-1:0] addr_q;
    logic          pass_q;
    logic          accept;
    logic          at_last;
    logic [DW-1:0] pat;
    logic [DW-1:0] sig_nxt;
    logic [DW-1:0] sig_unused;

    // Decode the state into the status outputs and the start acceptance.
    always_comb begin
        busy    = (state_q == ST_WRITE) || (state_q == ST_READ);
        done    = (state_q == ST_DONE);
        pass    = pass_q;
        accept  = start && !busy;
        at_last = (addr_q == LAST);
    end

    // Sequence the write pass, then the read pass, and record the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AUTO_START ? ST_WRITE : ST_IDLE;
            addr_q  <= '0;
            pass_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_WRITE: begin
                    addr_q <= at_last ? '0 : addr_q + AW'(1);
                    if (at_last) state_q <= ST_READ;
                end
                ST_READ: begin
                    addr_q <= at_last ? '0 : addr_q + AW'(1);
                    if (at_last) begin
                        state_q <= ST_DONE;
                        pass_q  <= (sig_nxt == EXP_SIG);
                    end
                end
                default: begin
                    if (accept) begin
                        state_q <= ST_WRITE;
                        addr_q  <= '0;
                        pass_q  <= 1'b0;
                    end
                end
            endcase
        end
    end

    bist_lfsr #(.DW(DW), .SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .advance (state_q == ST_WRITE),
        .q       (pat)
    );

    bist_misr #(.DW(DW)) u_misr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .en      (state_q == ST_READ),
        .din     (arr_rdata),
        .sig     (sig_unused),
        .sig_nxt (sig_nxt)
    );

    bist_port_mux #(.AW(AW), .DW(DW)) u_mux (
        .test_en   (busy),
        .sys_addr  (sys_addr),
        .sys_wdata (sys_wdata),
        .sys_we    (sys_we),
        .sys_rdata (sys_rdata),
        .tst_addr  (addr_q),
        .tst_wdata (pat),
        .tst_we    (state_q == ST_WRITE),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata),
        .arr_we    (arr_we),
        .arr_rdata (arr_rdata)
    );
endmodule

// File: rtl/array_bist_chk.sv
// Checker for array_bist: properties over its ports, attached to the top module with bind.
// Assumes a synchronous active-low reset; every property is disabled while reset is low.
module array_bist_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic          arr_we,
    input logic [AW-1:0] arr_addr,
    input logic [DW-1:0] sys_rdata
);
    // R6: done and busy are never high together.
    p_done_excl_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R6: pass is only reported together with done.
    p_pass_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    // R1: the normal port reads zero during a test.
    p_sys_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sys_rdata == '0));

    // R7: the verdict holds while no start arrives.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass)));

    // R8: a start accepted while idle begins a test on the next cycle.
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

    // R4: the address advances by one on every cycle within a pass.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && busy && $past(busy) && (arr_we == $past(arr_we)))
        |-> (arr_addr == $past(arr_addr) + AW'(1)));
endmodule

bind array_bist array_bist_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr),
    .sys_rdata (sys_rdata)
);

// File: tb/array_bist_tb.sv
// Directed bench for array_bist. It contains an array model with an optional stuck bit and
// computes the expected pattern and signature from the requirement formulas.
module array_bist_tb;
    localparam int         DEPTH = 16;
    localparam int         DW    = 8;
    localparam int         AW    = 4;
    localparam logic [7:0] SEED  = 8'hA5;
    localparam logic [7:0] TAPS  = 8'hB8;
    localparam int         FADDR = 5;
    localparam int         FBIT  = 2;

    // Applies one step of the shift-register formula in R3 and R5.
    function automatic logic [7:0] stepf(input logic [7:0] v);
        return {v[6:0], ^(v & TAPS)};
    endfunction

    // Returns the word that the write pass stores at address i (R3).
    function automatic logic [7:0] ref_data(input int i);
        logic [7:0] d = SEED;
        for (int k = 0; k < i; k++) d = stepf(d);
        return d;
    endfunction

    // Returns the signature that a fault-free array produces (R5).
    function automatic logic [7:0] ref_sig();
        logic [7:0] d = SEED;
        logic [7:0] s = '0;
        for (int k = 0; k < DEPTH; k++) begin
            s = stepf(s) ^ d;
            d = stepf(d);
        end
        return s;
    endfunction

    localparam logic [7:0] EXP = ref_sig();

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] sys_addr = '0;
    logic [DW-1:0] sys_wdata = '0;
    logic          sys_we = 1'b0;
    logic [DW-1:0] sys_rdata;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;
    logic          arr_we;
    logic [DW-1:0] arr_rdata;
    logic          busy, done, pass;
    logic          fault_on = 1'b0;
    logic [DW-1:0] mem [DEPTH];
    int            errors = 0;
    int            checks = 0;
    logic [7:0]    fword;

    always #5 clk = ~clk;

    array_bist #(.DEPTH(DEPTH), .DW(DW), .SEED(SEED), .EXP_SIG(EXP), .AUTO_START(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_we(sys_we), .sys_rdata(sys_rdata),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_we(arr_we), .arr_rdata(arr_rdata),
        .busy(busy), .done(done), .pass(pass)
    );

    // Array model: synchronous write, asynchronous read, and one bit stuck at the opposite of the pattern when enabled.
    always_ff @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;
    always_comb begin
        fword     = ref_data(FADDR);
        arr_rdata = mem[arr_addr];
        if (fault_on && (int'(arr_addr) == FADDR)) arr_rdata[FBIT] = ~fword[FBIT];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Follows one test window from the current negedge until done, checking order and data.
    task automatic follow_run(input bit poke_start);
        int n = 0;
        bit ord_ok = 1'b1;
        bit quiet_ok = 1'b1;
        while (!done && n < 4 * DEPTH) begin
            if (busy) begin
                if (n < DEPTH)
                    ord_ok &= (arr_we === 1'b1) && (int'(arr_addr) == n) && (arr_wdata === ref_data(n));
                else
                    ord_ok &= (arr_we === 1'b0) && (int'(arr_addr) == n - DEPTH);
                quiet_ok &= (sys_rdata === '0);
                n++;
            end
            start = poke_start && (n == 4);
            @(negedge clk);
        end
        start = 1'b0;
        check("R3 write then R4 read order and data", 32'(ord_ok), 32'd1);
        check("R1 sys_rdata zero while busy", 32'(quiet_ok), 32'd1);
        check("R4 busy window length", n, 2 * DEPTH);
        check("R6 done after last read", {busy, done}, 32'b01);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 busy next cycle after start", {busy, done}, 32'b10);
    endtask

    // Reset state and the automatic run at power-up, with normal-port writes held high throughout.
    task automatic t_reset_and_auto();
        repeat (3) @(negedge clk);
        check("R2 reset done/pass", {done, pass}, 32'b00);
        sys_we = 1'b1; sys_addr = AW'(3); sys_wdata = 8'hFF;
        rst_n = 1'b1;
        check("R2 busy after reset", busy, 1);
        follow_run(1'b0);
        sys_we = 1'b0;
        check("R6 pass on good array", pass, 1);
        for (int i = 0; i < DEPTH; i++) check("R3 array contents", mem[i], ref_data(i));
    endtask

    // The verdict holds, and the normal port is usable again after the test.
    task automatic t_hold_and_sys();
        repeat (5) @(negedge clk);
        check("R7 verdict held", {done, pass}, 32'b11);
        sys_addr = AW'(3);
        #1 check("R10 sys read after test (R1 no leak)", sys_rdata, ref_data(3));
        sys_addr = AW'(7); sys_wdata = 8'h3C; sys_we = 1'b1;
        @(negedge clk);
        sys_we = 1'b0;
        #1 check("R10 sys write then read", sys_rdata, 8'h3C);
    endtask

    // A stuck bit must fail; a start pulse in mid-run must be ignored.
    task automatic t_fault();
        fault_on = 1'b1;
        @(negedge clk);
        pulse_start();
        follow_run(1'b1);
        check("R9 stuck bit fails", pass, 0);
        check("R8 mid-run start ignored", {busy, done}, 32'b01);
    endtask

    // A rerun on the repaired array passes again.
    task automatic t_rerun();
        fault_on = 1'b0;
        @(negedge clk);
        pulse_start();
        check("R8 pass cleared at start", pass, 0);
        follow_run(1'b0);
        check("R5 signature matches on rerun", pass, 1);
    endtask

    initial begin
        t_reset_and_auto();
        t_hold_and_sys();
        t_fault();
        t_rerun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule